// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits between the two independent ports of a shared memory array and watches for both ports reaching the same word at the same time. Each port presents an enable, an address and a write request. The block registers them once. When both enables are active and the two addresses are equal, it decides which port arrived first. The other port, the later one, gets an active-low busy indication, and its write strobe toward the array is suppressed. Read strobes are never gated, so a blocked port still reads array data.

A strap input selects the role. In master mode the block makes the decision and drives both busy outputs. In slave mode the block ignores its own decision and holds both busy outputs high. Each per-port busy input then acts purely as a write inhibit for that port. Several slaves can therefore follow one master's decision when arrays are placed side by side to build a wider word. The arbitration looks only at enables and addresses; the direction of either access plays no part in it. When both ports arrive in the same clock cycle, the left port wins.

Top module: `collision_arbiter`

## Requirements
- R1: A collision exists only when both registered enables are high and the registered addresses are equal in every bit. Without a collision, both busy outputs are high (1).
- R2: Master mode: a port blocks the other only if it became active on an address first. The later port's busy output goes low (0). This holds while neither side changes its enable or address.
- R3: The two busy outputs are never low in the same cycle.
- R4: Master mode, simultaneous arrival: if both ports' requests change in the same cycle into a collision, the right port is blocked (right busy low, left busy high).
- R5: The write-request inputs have no effect on which port is blocked.
- R6: Master mode: the write-enable output of a blocked port is low whatever its write request. The read-enable output is high whenever the port is enabled with write request low, blocked or not.
- R7: Slave mode (isMaster = 0): both busy outputs are high. A low level on a port's busy input forces that port's write enable low in the same cycle. The busy input does not affect that port's read enable.
- R8: Master mode: busy is released, with both outputs high, when the addresses stop matching or when either enable drops.
- R9: Latency: a change at the inputs appears on the busy outputs after the second rising clock edge, not the first. The write and read enable outputs reflect the request captured at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isMaster | input | 1 | 1: generate busy; 0: accept busy inputs as write inhibits |
| leftEn | input | 1 | Left port enable |
| leftAddr | input | ADDR_W | Left port address |
| leftWrReq | input | 1 | Left port write request (0 means read) |
| leftBusyInN | input | 1 | Left write inhibit, active low, used in slave mode |
| rightEn | input | 1 | Right port enable |
| rightAddr | input | ADDR_W | Right port address |
| rightWrReq | input | 1 | Right port write request (0 means read) |
| rightBusyInN | input | 1 | Right write inhibit, active low, used in slave mode |
| leftBusyOutN | output | 1 | Left busy, active low |
| rightBusyOutN | output | 1 | Right busy, active low |
| leftWrEn | output | 1 | Gated left write strobe to the array |
| rightWrEn | output | 1 | Gated right write strobe to the array |
| leftRdEn | output | 1 | Left read strobe to the array |
| rightRdEn | output | 1 | Right read strobe to the array |

## Verification
A wrong ownership state shows up at the busy pins two rising edges after the offending input change. Examples are a busy left set after release, the wrong side blocked, or a tie resolved to the right. The same edge shows a write strobe passed to, or withheld from, the wrong port. The bench sweeps every address pair of a 3-bit configuration under left-first, right-first and simultaneous arrival, with varied write requests. It samples after one edge, to catch busy arriving early, and after two, to catch it arriving late. Release is checked both by dropping an enable and by moving an address. Slave mode is checked over every combination of busy inputs and write requests.

// File: rtl/collision_arbiter_pkg.sv
package collision_arbiter_pkg;
  localparam int NUM_PORTS = 2;
  localparam int LEFT_IDX  = 0;
  localparam int RIGHT_IDX = 1;

  // Status from the datapath compare stage to the control.
  typedef struct packed {
    logic match;     // both enabled, same address (registered stage)
    logic newLeft;   // left request changed this cycle
    logic newRight;  // right request changed this cycle
  } cmpStatus_t;

  // Strobes from the control back to the datapath.
  typedef struct packed {
    logic blockLeft;
    logic blockRight;
  } blockStrobe_t;

  typedef enum logic [1:0] {
    ARB_IDLE       = 2'd0,
    ARB_LEFT_OWNS  = 2'd1,
    ARB_RIGHT_OWNS = 2'd2
  } arbState_t;
endpackage

// File: rtl/collision_arbiter_datapath.sv
module collision_arbiter_datapath
  import collision_arbiter_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 isMaster,
  input  logic [NUM_PORTS-1:0]                 reqEn,
  input  logic [NUM_PORTS-1:0]                 reqWr,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     reqAddr,
  input  logic [NUM_PORTS-1:0]                 busyInN,
  input  blockStrobe_t                         blk,
  output cmpStatus_t                           status,
  output logic [NUM_PORTS-1:0]                 wrEn,
  output logic [NUM_PORTS-1:0]                 rdEn,
  output logic [NUM_PORTS-1:0]                 busyOutN
);
  // Capture stage (first register) and aligned stage (second register).
  logic              capEn   [NUM_PORTS];
  logic              capWr   [NUM_PORTS];
  logic [ADDR_W-1:0] capAddr [NUM_PORTS];
  logic              algEn   [NUM_PORTS];
  logic              algWr   [NUM_PORTS];
  logic [ADDR_W-1:0] algAddr [NUM_PORTS];
  logic [NUM_PORTS-1:0] fresh;
  logic [NUM_PORTS-1:0] blkVec;
  logic [NUM_PORTS-1:0] inhibit;

  assign blkVec = {blk.blockRight, blk.blockLeft};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        capEn[p]   <= 1'b0;
        capWr[p]   <= 1'b0;
        capAddr[p] <= '0;
        algEn[p]   <= 1'b0;
        algWr[p]   <= 1'b0;
        algAddr[p] <= '0;
      end else begin
        capEn[p]   <= reqEn[p];
        capWr[p]   <= reqWr[p];
        capAddr[p] <= reqAddr[p];
        algEn[p]   <= capEn[p];
        algWr[p]   <= capWr[p];
        algAddr[p] <= capAddr[p];
      end
    end

    // A request is new when its enable just rose or its address moved.
    assign fresh[p] = capEn[p] & (~algEn[p] | (capAddr[p] != algAddr[p]));

    // Master uses its own decision; slave uses the external inhibit pin.
    assign inhibit[p]  = isMaster ? blkVec[p] : ~busyInN[p];
    assign wrEn[p]     = algEn[p] & algWr[p] & ~inhibit[p];
    assign rdEn[p]     = algEn[p] & ~algWr[p];
    assign busyOutN[p] = isMaster ? ~blkVec[p] : 1'b1;

    // R7: slave busy pins stay high and the inhibit input kills writes.
    a_r7_slave_busy_high: assert property (@(posedge clk) disable iff (!rstN)
      !isMaster |-> busyOutN[p]);
    a_r7_slave_inhibit: assert property (@(posedge clk) disable iff (!rstN)
      (!isMaster && !busyInN[p]) |-> !wrEn[p]);
    // R6: a port shown busy in master mode never writes.
    a_r6_blocked_no_write: assert property (@(posedge clk) disable iff (!rstN)
      (isMaster && !busyOutN[p]) |-> !wrEn[p]);
  end

  assign status.match    = capEn[LEFT_IDX] & capEn[RIGHT_IDX] &
                           (capAddr[LEFT_IDX] == capAddr[RIGHT_IDX]);
  assign status.newLeft  = fresh[LEFT_IDX];
  assign status.newRight = fresh[RIGHT_IDX];
endmodule

// File: rtl/collision_arbiter_control.sv
module collision_arbiter_control
  import collision_arbiter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  cmpStatus_t   status,
  output blockStrobe_t blk
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (!status.match) begin
      stateNext = ARB_IDLE;
    end else if (state != ARB_IDLE && !status.newLeft && !status.newRight) begin
      stateNext = state;                 // collision unchanged: keep owner
    end else if (status.newLeft && !status.newRight) begin
      stateNext = ARB_RIGHT_OWNS;        // right was there first
    end else begin
      stateNext = ARB_LEFT_OWNS;         // left first, or tie -> left wins
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ARB_IDLE;
    else       state <= stateNext;
  end

  assign blk.blockLeft  = (state == ARB_RIGHT_OWNS);
  assign blk.blockRight = (state == ARB_LEFT_OWNS);

  // R1 / R8: no collision means both ports free on the next cycle.
  a_r1_no_match_free: assert property (@(posedge clk) disable iff (!rstN)
    !status.match |=> (!blk.blockLeft && !blk.blockRight));
  // R4: simultaneous arrival favours the left port.
  a_r4_tie_left: assert property (@(posedge clk) disable iff (!rstN)
    (status.match && status.newLeft && status.newRight) |=> blk.blockRight);
  // R2: the later arrival is blocked.
  a_r2_later_right: assert property (@(posedge clk) disable iff (!rstN)
    (status.match && status.newRight && !status.newLeft) |=> blk.blockRight);
  a_r2_later_left: assert property (@(posedge clk) disable iff (!rstN)
    (status.match && status.newLeft && !status.newRight) |=> blk.blockLeft);
  // R2: an unchanged collision keeps its owner.
  a_r2_hold_owner: assert property (@(posedge clk) disable iff (!rstN)
    (status.match && (blk.blockLeft || blk.blockRight) &&
     !status.newLeft && !status.newRight) |=> $stable(blk));
endmodule

// File: rtl/collision_arbiter.sv
module collision_arbiter
  import collision_arbiter_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWrReq,
  input  logic              leftBusyInN,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWrReq,
  input  logic              rightBusyInN,
  output logic              leftBusyOutN,
  output logic              rightBusyOutN,
  output logic              leftWrEn,
  output logic              rightWrEn,
  output logic              leftRdEn,
  output logic              rightRdEn
);
  cmpStatus_t                status;
  blockStrobe_t              blk;
  logic [NUM_PORTS-1:0]      wrEnVec, rdEnVec, busyOutVec;

  collision_arbiter_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .isMaster (isMaster),
    .reqEn    ({rightEn, leftEn}),
    .reqWr    ({rightWrReq, leftWrReq}),
    .reqAddr  ({rightAddr, leftAddr}),
    .busyInN  ({rightBusyInN, leftBusyInN}),
    .blk      (blk),
    .status   (status),
    .wrEn     (wrEnVec),
    .rdEn     (rdEnVec),
    .busyOutN (busyOutVec)
  );

  collision_arbiter_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .blk    (blk)
  );

  assign leftBusyOutN  = busyOutVec[LEFT_IDX];
  assign rightBusyOutN = busyOutVec[RIGHT_IDX];
  assign leftWrEn      = wrEnVec[LEFT_IDX];
  assign rightWrEn     = wrEnVec[RIGHT_IDX];
  assign leftRdEn      = rdEnVec[LEFT_IDX];
  assign rightRdEn     = rdEnVec[RIGHT_IDX];

  // R3: the two busy outputs are never low together.
  a_r3_busy_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    leftBusyOutN || rightBusyOutN);
endmodule

// File: tb/collision_arbiter_bench.sv
module collision_arbiter_bench;
  localparam int AW = 3;
  localparam int NADDR = 1 << AW;

  logic clk = 1'b0;
  logic rstN;
  logic isMaster;
  logic leftEn, leftWrReq, leftBusyInN;
  logic rightEn, rightWrReq, rightBusyInN;
  logic [AW-1:0] leftAddr, rightAddr;
  logic leftBusyOutN, rightBusyOutN, leftWrEn, rightWrEn, leftRdEn, rightRdEn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  collision_arbiter #(.ADDR_W(AW)) u_collision_arbiter (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .leftEn(leftEn), .leftAddr(leftAddr), .leftWrReq(leftWrReq),
    .leftBusyInN(leftBusyInN),
    .rightEn(rightEn), .rightAddr(rightAddr), .rightWrReq(rightWrReq),
    .rightBusyInN(rightBusyInN),
    .leftBusyOutN(leftBusyOutN), .rightBusyOutN(rightBusyOutN),
    .leftWrEn(leftWrEn), .rightWrEn(rightWrEn),
    .leftRdEn(leftRdEn), .rightRdEn(rightRdEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Checks outputs against expected blocking of each side.
  task automatic chk_all(input string tag, input logic blkL, input logic blkR,
                         input logic enL, input logic wL, input logic enR, input logic wR);
    chk({tag, " R3 left busy"},  leftBusyOutN,  ~blkL);
    chk({tag, " R3 right busy"}, rightBusyOutN, ~blkR);
    chk({tag, " R6 left wr"},    leftWrEn,  enL & wL & ~blkL);
    chk({tag, " R6 right wr"},   rightWrEn, enR & wR & ~blkR);
    chk({tag, " R6 left rd"},    leftRdEn,  enL & ~wL);
    chk({tag, " R6 right rd"},   rightRdEn, enR & ~wR);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rstN = 1'b0; isMaster = 1'b1;
    leftEn = 0; leftWrReq = 0; leftBusyInN = 1; leftAddr = '0;
    rightEn = 0; rightWrReq = 0; rightBusyInN = 1; rightAddr = '0;
    tick(3);
    // Reset state.
    chk("reset R1 left busy", leftBusyOutN, 1'b1);
    chk("reset R1 right busy", rightBusyOutN, 1'b1);
    chk("reset R6 left wr", leftWrEn, 1'b0);
    chk("reset R6 right wr", rightWrEn, 1'b0);
    rstN = 1'b1;
    tick(2);

    // Master sweep: every address pair, three arrival orders.
    for (int a = 0; a < NADDR; a++) begin
      for (int b = 0; b < NADDR; b++) begin
        for (int ord = 0; ord < 3; ord++) begin
          logic wL, wR, hit, bL, bR;
          int k;
          k = a * 24 + b * 3 + ord;
          wL = k[0];          // R5: write requests vary across the sweep
          wR = k[1] ^ k[2];
          hit = (a == b);
          bL = hit && (ord == 1);   // left arrived later
          bR = hit && (ord != 1);   // right later, or tie -> R4
          leftEn = 0; rightEn = 0;
          tick(3);
          if (ord == 0) begin
            leftEn = 1; leftAddr = AW'(a); leftWrReq = wL;
            tick(2);
            chk_all("single-left R1", 1'b0, 1'b0, 1'b1, wL, 1'b0, 1'b0);
            rightEn = 1; rightAddr = AW'(b); rightWrReq = wR;
          end else if (ord == 1) begin
            rightEn = 1; rightAddr = AW'(b); rightWrReq = wR;
            tick(2);
            chk_all("single-right R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, wR);
            leftEn = 1; leftAddr = AW'(a); leftWrReq = wL;
          end else begin
            leftEn = 1; leftAddr = AW'(a); leftWrReq = wL;
            rightEn = 1; rightAddr = AW'(b); rightWrReq = wR;
          end
          tick(1);
          // R9: one edge later busy has not yet moved.
          chk("R9 left busy early", leftBusyOutN, 1'b1);
          chk("R9 right busy early", rightBusyOutN, 1'b1);
          tick(1);
          chk_all(ord == 2 ? "tie R4" : "order R2", bL, bR, 1'b1, wL, 1'b1, wR);
          tick(2);
          chk_all("hold R2", bL, bR, 1'b1, wL, 1'b1, wR);
          if (hit) begin
            if (k[3]) leftEn = 0;
            else rightAddr = AW'((b + 1) % NADDR);
            tick(1);
            chk("R9 release not early L", leftBusyOutN, ~bL);
            chk("R9 release not early R", rightBusyOutN, ~bR);
            tick(1);
            chk_all("release R8", 1'b0, 1'b0, ~k[3], wL, 1'b1, wR);
          end
        end
      end
    end

    // Slave mode: decision ignored, busy inputs act as write inhibits.
    isMaster = 1'b0;
    leftEn = 0; rightEn = 0;
    tick(3);
    leftEn = 1; rightEn = 1; leftAddr = 3'd5; rightAddr = 3'd5;
    for (int bi = 0; bi < 4; bi++) begin
      for (int w = 0; w < 4; w++) begin
        leftBusyInN = bi[0]; rightBusyInN = bi[1];
        leftWrReq = w[0]; rightWrReq = w[1];
        tick(2);
        chk("R7 slave left busy out", leftBusyOutN, 1'b1);
        chk("R7 slave right busy out", rightBusyOutN, 1'b1);
        chk("R7 slave left wr", leftWrEn, w[0] & bi[0]);
        chk("R7 slave right wr", rightWrEn, w[1] & bi[1]);
        chk("R7 slave left rd", leftRdEn, ~w[0]);
        chk("R7 slave right rd", rightRdEn, ~w[1]);
      end
    end
    finish_run();
  end
endmodule